// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the clock sent to an SD card from a faster reference clock. Software writes a 32-bit control word through a write strobe. The word picks the divide ratio, switches the card clock on or off, and can ask for the clock to pause on its own while the bus has nothing to do. The block holds the card clock low whenever it is stopped. It never shortens a high or low phase, so the card sees no glitch when the ratio changes, when the clock stops or when it restarts.

Most ratios come from a one-hot field in which each bit stands for a power of two. Two separate override bits select the fastest setting, where the reference clock passes straight through, and the slowest setting, divide by 1024. A status output reports whether the card clock is running. It goes high only after one complete output period, so software can tell when the new setting has settled.

To change the ratio, software normally clears the enable bit, writes the new ratio, and then sets the enable bit again. A ratio that is written while the clock runs is still taken up safely, at the next low-phase boundary.

Top module: `sdclk_divider`

## Requirements
- R1: While reset is asserted and just after it is released, `card_clk` and `clk_running` are low and the stored control word is zero, so the enable bit is clear.
- R2: The control word is stored only in a reference cycle with `ctl_wr` high. A change on `ctl_word` without the strobe does not change the output ratio.
- R3: Bits 7:0 form the ratio field. If bit k is the highest set bit, the output period is 4·2^k reference cycles: bit 0 gives 4 and bit 7 gives 512. The highest set bit wins when several bits are set.
- R4: If bits 7:0, bit 10 and bit 16 are all clear, the output period is 2 reference cycles.
- R5: Bit 10 set makes the output follow the reference clock directly (pass-through). It takes priority over bit 16 and over bits 7:0. The pass-through path and the divided path never drive the output at the same time.
- R6: Bit 16 set, with bit 10 clear, gives a period of 1024 reference cycles, whatever bits 7:0 hold.
- R7: Bit 8 is the enable bit. When it is clear, the output finishes the phase it is in and then stays low. Every divided output has high and low phases of equal length.
- R8: Bit 9 turns on auto-stop. With bit 9 set, the output is held low while `bus_busy` is low and runs while `bus_busy` is high.
- R9: A ratio written while the clock runs takes effect only at the end of a low phase. No high phase is shorter than half of the old period or half of the new one.
- R10: `clk_running` rises on the reference edge that starts the second output period after a start. It falls when the output stops, and it stays high across a change of ratio while the clock runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_word | input | 32 | Control word: ratio field, enable, auto-stop, override bits |
| ctl_wr | input | 1 | Write strobe for `ctl_word` |
| bus_busy | input | 1 | High while a card transfer is in progress |
| card_clk | output | 1 | Clock to the card |
| clk_running | output | 1 | High while the card clock runs steadily |

## Verification
The bench measures the period and the high time of every ratio, including the default divide-by-2, the divide-by-1024 override and a ratio field with several bits set. A decoder with the wrong priority or with an off-by-one in the shift would show up there as a period that is half or twice the expected value. It switches into and out of pass-through and checks that the reference-clock level appears at the output only in that mode; a design that let both paths drive the output would show the reference clock while dividing. It changes the ratio while the clock runs and measures every high pulse, which catches a design that reloads its counter in the middle of a phase and so produces a short runt pulse. It also stops the clock by clearing the enable bit and by auto-stop, and it times the rise of `clk_running` against the first two output periods after a start.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CTL_W     = 32;
  localparam int RATIO_W   = 8;
  localparam int BIT_EN    = 8;
  localparam int BIT_AUTO  = 9;
  localparam int BIT_BYP   = 10;
  localparam int BIT_SLOW  = 16;
  localparam int SHIFT_W   = 4;
  localparam int SHIFT_BYP  = 0;
  localparam int SHIFT_DIV2 = 1;
  localparam int SHIFT_SLOW = RATIO_W + 2;
  localparam int CNT_W     = SHIFT_SLOW - 1;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               en;
    logic               auto_stop;
    logic               bypass;
    logic               slow;
  } ctl_t;

  // log2 of the divide ratio: 0 pass-through, 1 div2, k+2 for ratio bit k, 10 div1024
  function automatic logic [SHIFT_W-1:0] ratio_shift(ctl_t c);
    logic [SHIFT_W-1:0] s;
    s = SHIFT_W'(SHIFT_DIV2);
    for (int i = 0; i < RATIO_W; i++) begin
      if (c.ratio[i]) s = SHIFT_W'(i + 2);
    end
    if (c.slow)   s = SHIFT_W'(SHIFT_SLOW);
    if (c.bypass) s = SHIFT_W'(SHIFT_BYP);
    return s;
  endfunction

  // last count value of one half period for a given shift
  function automatic logic [CNT_W-1:0] half_last(logic [SHIFT_W-1:0] s);
    logic [CNT_W:0] p;
    if (s == SHIFT_W'(SHIFT_BYP)) return '0;
    p = (CNT_W+1)'(1) << (s - SHIFT_W'(1));
    return CNT_W'(p - (CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/sdclk_ctl_reg.sv
module sdclk_ctl_reg
  import sdclk_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             ctl_wr,
  output ctl_t             ctl_q
);
  ctl_t ctl_next;

  always_comb begin
    ctl_next.ratio     = ctl_word[RATIO_W-1:0];
    ctl_next.en        = ctl_word[BIT_EN];
    ctl_next.auto_stop = ctl_word[BIT_AUTO];
    ctl_next.bypass    = ctl_word[BIT_BYP];
    ctl_next.slow      = ctl_word[BIT_SLOW];
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_next;
  end
endmodule

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec
  import sdclk_pkg::*;
(
  input  ctl_t               ctl_q,
  input  logic               bus_busy,
  output logic [SHIFT_W-1:0] new_shift,
  output logic               run_req
);
  always_comb begin
    new_shift = ratio_shift(ctl_q);
    run_req   = ctl_q.en && (!ctl_q.auto_stop || bus_busy);
  end
endmodule

// File: rtl/sdclk_engine.sv
module sdclk_engine
  import sdclk_pkg::*;
(
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               run_req,
  input  logic [SHIFT_W-1:0] new_shift,
  output logic               card_clk,
  output logic               clk_running,
  output logic               div_q,
  output logic               gate_q,
  output logic [SHIFT_W-1:0] act_shift
);
  logic             busy_d;
  logic [CNT_W-1:0] cnt;
  logic             pulse_seen;
  logic             cnt_end;
  logic             want_div;
  logic             want_byp;

  always_comb begin
    cnt_end  = (cnt == half_last(act_shift));
    want_div = run_req && (new_shift != SHIFT_W'(SHIFT_BYP));
    want_byp = !busy_d && (act_shift == SHIFT_W'(SHIFT_BYP)) &&
               (new_shift == SHIFT_W'(SHIFT_BYP)) && run_req;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      busy_d      <= 1'b0;
      div_q       <= 1'b0;
      cnt         <= '0;
      act_shift   <= SHIFT_W'(SHIFT_DIV2);
      clk_running <= 1'b0;
      pulse_seen  <= 1'b0;
    end else if (busy_d) begin
      if (cnt_end) begin
        cnt <= '0;
        if (div_q) begin
          div_q <= 1'b0;
        end else begin
          act_shift <= new_shift;
          if (want_div) begin
            div_q       <= 1'b1;
            clk_running <= 1'b1;
          end else begin
            busy_d      <= 1'b0;
            clk_running <= 1'b0;
          end
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else if (gate_q) begin
      pulse_seen  <= 1'b1;
      clk_running <= pulse_seen;
    end else begin
      pulse_seen  <= 1'b0;
      clk_running <= 1'b0;
      act_shift   <= new_shift;
      if (want_div) begin
        busy_d <= 1'b1;
        div_q  <= 1'b1;
        cnt    <= '0;
      end
    end
  end

  // pass-through gate changes only while the reference clock is low
  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= want_byp;
  end

  assign card_clk = div_q | (clk_ref & gate_q);
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             ctl_wr,
  input  logic             bus_busy,
  output logic             card_clk,
  output logic             clk_running
);
  ctl_t               ctl_q;
  logic [SHIFT_W-1:0] new_shift;
  logic               run_req;
  logic               div_q;
  logic               gate_q;
  logic [SHIFT_W-1:0] act_shift;

  sdclk_ctl_reg u_ctl (
    .clk_ref(clk_ref), .rst_n(rst_n), .ctl_word(ctl_word),
    .ctl_wr(ctl_wr), .ctl_q(ctl_q)
  );

  sdclk_ratio_dec u_dec (
    .ctl_q(ctl_q), .bus_busy(bus_busy),
    .new_shift(new_shift), .run_req(run_req)
  );

  sdclk_engine u_eng (
    .clk_ref(clk_ref), .rst_n(rst_n), .run_req(run_req),
    .new_shift(new_shift), .card_clk(card_clk),
    .clk_running(clk_running), .div_q(div_q), .gate_q(gate_q),
    .act_shift(act_shift)
  );
endmodule

// File: rtl/sdclk_chk.sv
module sdclk_chk
  import sdclk_pkg::*;
(
  input logic               clk_ref,
  input logic               rst_n,
  input logic               run_req,
  input logic               div_q,
  input logic               gate_q,
  input logic [SHIFT_W-1:0] act_shift,
  input logic               clk_running
);
  // R9
  ratio_at_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act_shift != $past(act_shift)) |-> (!$past(div_q) && !$past(gate_q)));

  // R5
  no_dual_drive_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(div_q && gate_q));

  // R7
  stop_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!$past(run_req) && !$past(div_q)) |-> !div_q);

  // R10
  running_req_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_running) |-> $past(run_req));

  // R10
  running_active_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_running) |-> (div_q || gate_q));

  // R3
  shift_range_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    act_shift <= SHIFT_W'(SHIFT_SLOW));
endmodule

bind sdclk_divider sdclk_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .run_req(run_req), .div_q(div_q),
  .gate_q(gate_q), .act_shift(act_shift), .clk_running(clk_running)
);

// File: tb/test_sdclk_divider.sv
`timescale 1ns/1ps
module test_sdclk_divider;
  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl_word = '0;
  logic        ctl_wr = 1'b0;
  logic        bus_busy = 1'b0;
  logic        card_clk;
  logic        clk_running;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [31:0] EN   = 32'h0000_0100;
  localparam logic [31:0] AUTO = 32'h0000_0200;
  localparam logic [31:0] BYP  = 32'h0000_0400;
  localparam logic [31:0] SLOW = 32'h0001_0000;

  always #2.5 clk_ref = ~clk_ref;

  sdclk_divider i_sdclk_divider (
    .clk_ref(clk_ref), .rst_n(rst_n), .ctl_word(ctl_word), .ctl_wr(ctl_wr),
    .bus_busy(bus_busy), .card_clk(card_clk), .clk_running(clk_running)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_ref);
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_ctl(input logic [31:0] w);
    step();
    ctl_word = w;
    ctl_wr = 1'b1;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic prog(input logic [31:0] w);
    write_ctl(w & ~EN);
    wait_cyc(1100);
    write_ctl(w);
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    int guard;
    prev = 1'b1;
    guard = 0;
    per = 0;
    hi = 0;
    while (guard < 5000) begin
      step();
      if (card_clk && !prev) break;
      prev = card_clk;
      guard++;
    end
    per = 1;
    hi = 1;
    prev = 1'b1;
    guard = 0;
    while (guard < 5000) begin
      step();
      if (card_clk && !prev) break;
      per++;
      if (card_clk) hi++;
      prev = card_clk;
      guard++;
    end
  endtask

  task automatic expect_div(input int exp, input string req);
    int per, hi;
    measure(per, hi);
    chk(per == exp, req, per, exp);
    chk(hi == exp / 2, "R7 duty", hi, exp / 2);
  endtask

  task automatic expect_low(input int n, input string req);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (card_clk) highs++;
    end
    chk(highs == 0, req, highs, 0);
    chk(clk_running == 1'b0, {req, " running"}, int'(clk_running), 0);
  endtask

  task automatic t_reset();
    int highs;
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (card_clk || clk_running) highs++;
    end
    chk(highs == 0, "R1 reset outputs", highs, 0);
  endtask

  task automatic t_default();
    prog(EN);
    expect_div(2, "R4 default div2");
  endtask

  task automatic t_onehot();
    for (int i = 0; i < 8; i++) begin
      prog(EN | (32'h1 << i));
      expect_div(4 << i, "R3 one-hot ratio");
    end
  endtask

  task automatic t_multi();
    prog(EN | 32'h05);
    expect_div(16, "R3 highest bit wins");
    prog(EN | 32'hFF);
    expect_div(512, "R3 all bits");
  endtask

  task automatic t_slow();
    prog(EN | SLOW);
    expect_div(1024, "R6 div1024");
    prog(EN | SLOW | 32'h01);
    expect_div(1024, "R6 priority over field");
  endtask

  task automatic t_bypass();
    int bad;
    bad = 0;
    prog(EN | BYP | SLOW | 32'h10);
    wait_cyc(10);
    for (int i = 0; i < 8; i++) begin
      step();
      if (!card_clk) bad++;
      @(negedge clk_ref);
      #1;
      if (card_clk) bad++;
    end
    chk(bad == 0, "R5 pass-through", bad, 0);
    chk(clk_running == 1'b1, "R5 pass-through running", int'(clk_running), 1);
    prog(EN | 32'h01);
    expect_div(4, "R5 leave pass-through");
  endtask

  task automatic t_disable();
    prog(EN | 32'h01);
    wait_cyc(20);
    write_ctl(32'h01);
    wait_cyc(20);
    expect_low(100, "R7 enable clear");
  endtask

  task automatic t_auto();
    bus_busy = 1'b0;
    prog(EN | AUTO | 32'h02);
    wait_cyc(20);
    expect_low(50, "R8 idle bus");
    bus_busy = 1'b1;
    expect_div(8, "R8 busy bus");
    bus_busy = 1'b0;
    wait_cyc(20);
    expect_low(50, "R8 idle again");
  endtask

  task automatic t_running();
    logic prev;
    int rises;
    int guard;
    write_ctl(32'h02);
    wait_cyc(20);
    write_ctl(EN | 32'h02);
    prev = 1'b0;
    rises = 0;
    guard = 0;
    while (rises < 2 && guard < 200) begin
      step();
      if (card_clk && !prev) begin
        rises++;
        if (rises == 1) chk(clk_running == 1'b0, "R10 first period", int'(clk_running), 0);
        else            chk(clk_running == 1'b1, "R10 second period", int'(clk_running), 1);
      end
      prev = card_clk;
      guard++;
    end
    chk(rises == 2, "R10 two rises", rises, 2);
  endtask

  task automatic t_onfly();
    int hl;
    int bad;
    int drops;
    int guard;
    prog(EN | 32'h01);
    wait_cyc(20);
    write_ctl(EN | 32'h04);
    guard = 0;
    while (card_clk && guard < 20) begin
      step();
      guard++;
    end
    hl = 0;
    bad = 0;
    drops = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (!clk_running) drops++;
      if (card_clk) hl++;
      else if (hl > 0) begin
        if (hl != 2 && hl != 8) bad++;
        hl = 0;
      end
    end
    chk(bad == 0, "R9 no short pulse", bad, 0);
    chk(drops == 0, "R10 stays running", drops, 0);
    expect_div(16, "R9 new ratio");
  endtask

  task automatic t_nostrobe();
    prog(EN | 32'h01);
    step();
    ctl_word = EN | 32'h80;
    wait_cyc(30);
    expect_div(4, "R2 no strobe");
  endtask

  initial begin
    repeat (190000) @(posedge clk_ref);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk(card_clk == 1'b0, "R1 in reset", int'(card_clk), 0);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_onehot();
    t_multi();
    t_slow();
    t_bypass();
    t_disable();
    t_auto();
    t_running();
    t_onfly();
    t_nostrobe();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule